// File: doc/BRIEF.md
# Power-Up Strap Sampling Sequencer

This block manages a group of shared pins. Each pin reads a configuration strap while the supply comes up and drives a clock once the device is running. When the supply-good indication rises, a window counted in reference-clock cycles begins. For the whole window every shared pin's output buffer stays disabled (three-state), so the external strap resistors set the pad levels.

On the last cycle of the window the synchronized pad levels are captured into a configuration register. On the following cycle the ready flag and every output enable turn on, which hands the pins over to clock duty. The captured bits are split into two fields:
- a frequency-select field that picks the processor/bus frequency pair and the spread setting;
- a single pin-function bit that decides whether a neighbouring pin is a reference-clock output or a bus-clock stop input.

Once captured, the configuration is frozen. Only a drop of the supply-good input clears it, and that drop acts asynchronously. No other reset exists.

Top module: `strap_capture_seq`

## Requirements
- R1: While `pwr_ok` is low, `pad_oe` is all zeros, `ready` is 0, and `freq_sel` and `pin_mode` are 0. This holds asynchronously, without waiting for a clock edge.
- R2: Count the rising clock edges after `pwr_ok` rises as 1, 2, 3 and so on. After edges 1 to WIN_CYCLES-1, `ready` and `pad_oe` stay 0. After edge WIN_CYCLES, `ready` is 1 and every bit of `pad_oe` is 1.
- R3: After edge WIN_CYCLES, the captured configuration equals the value `pad_in` held at edge WIN_CYCLES-2. This reflects two synchronizer stages. Pad changes after that edge are not captured.
- R4: Once `ready` is 1, it stays 1. `freq_sel` and `pin_mode` also keep their values, whatever `pad_in` does, for as long as `pwr_ok` stays high.
- R5: `freq_sel` bit i carries the captured level of `pad_in` bit i, for i from 0 to N_PINS-2. `pin_mode` carries the captured level of `pad_in` bit N_PINS-1.
- R6: A drop of `pwr_ok`, either within the window or after capture, discards all state. The next rise of `pwr_ok` starts a complete new window from edge 1 and captures fresh strap values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that times the window |
| pwr_ok | input | 1 | Supply-good indication; low acts as asynchronous power-on reset |
| pad_in | input | N_PINS | Pad input levels of the shared pins |
| pad_oe | output | N_PINS | Output-buffer enables of the shared pins, 1 = driving |
| freq_sel | output | N_PINS-1 | Captured frequency-select straps |
| pin_mode | output | 1 | Captured pin-function strap |
| ready | output | 1 | High once the straps are captured and the pins are outputs |

## Verification
The first power-up drives a new pad pattern on every cycle. Only one sample lands in the configuration, so this separates the correct two-stage capture point from an off-by-one in the counter or the synchronizer depth. After capture the pads keep toggling, which shows whether the register and the enables are truly frozen. A supply drop in the middle of the window, followed by a second power-up with a different strap pattern, shows whether the count restarts from zero. A final drop after capture, with all-ones straps, shows that nothing survives a power cycle and exercises every field bit at the other level.

// File: rtl/strap_capture_seq.sv
module strap_capture_seq #(
  parameter int N_PINS     = 5,
  parameter int WIN_CYCLES = 28636
) (
  input  logic              clk,
  input  logic              pwr_ok,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-2:0] freq_sel,
  output logic              pin_mode,
  output logic              ready
);
  localparam int CW = $clog2(WIN_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0]     cnt;
  logic [N_PINS-1:0] sync1, sync2, cfg;
  logic              done;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      cnt   <= '0;
      sync1 <= '0;
      sync2 <= '0;
      cfg   <= '0;
      done  <= 1'b0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      if (!done) begin
        if (cnt == LAST) begin
          cfg  <= sync2;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ready    = done;
  assign pad_oe   = {N_PINS{done}};
  assign freq_sel = cfg[N_PINS-2:0];
  assign pin_mode = cfg[N_PINS-1];

  // R2: buffers stay off until the terminal cycle has passed
  a_r2_closed_in_window: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!done && cnt != LAST) |=> (pad_oe == '0 && !ready));

  // R2: terminal cycle opens every buffer on the next cycle
  a_r2_open_after_terminal: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!done && cnt == LAST) |=> (ready && pad_oe == '1));

  // R3: capture takes the second synchronizer stage
  a_r3_capture_sync: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!done && cnt == LAST) |=> ({pin_mode, freq_sel} == $past(sync2)));

  // R4: configuration and ready frozen after capture
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!pwr_ok)
    ready |=> (ready && $stable(freq_sel) && $stable(pin_mode)));

endmodule

// File: tb/strap_capture_seq_test.sv
module strap_capture_seq_test;
  localparam int N   = 5;
  localparam int WIN = 12;

  logic         clk = 1'b0;
  logic         pwr_ok = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe;
  logic [N-2:0] freq_sel;
  logic         pin_mode;
  logic         ready;

  int total = 0;
  int bad = 0;
  int edges = 0;
  int session = 0;
  logic [N-1:0] cap = '0;
  bit finished = 0;

  strap_capture_seq #(.N_PINS(N), .WIN_CYCLES(WIN)) uut (
    .clk(clk), .pwr_ok(pwr_ok), .pad_in(pad_in), .pad_oe(pad_oe),
    .freq_sel(freq_sel), .pin_mode(pin_mode), .ready(ready)
  );

  always #4 clk = ~clk;

  // behavioural model: edge count since supply good, capture sample
  always @(posedge clk) begin
    if (!pwr_ok) begin
      edges = 0;
      cap   = '0;
    end else begin
      edges = edges + 1;
      if (edges == WIN - 2) cap = pad_in;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0h expected=%0h", tag, edges, act, exp);
    end
  endtask

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      if (!pwr_ok) begin
        check("R1 oe", 32'(pad_oe), 0);
        check("R1 ready", 32'(ready), 0);
        check("R1 cfg", 32'({pin_mode, freq_sel}), 0);
      end else if (edges < WIN) begin
        check(session > 1 ? "R6 window oe" : "R2 window oe", 32'(pad_oe), 0);
        check(session > 1 ? "R6 window ready" : "R2 window ready", 32'(ready), 0);
        check("R2 cfg empty", 32'({pin_mode, freq_sel}), 0);
      end else begin
        check(edges == WIN ? "R2 ready" : "R4 ready held", 32'(ready), 1);
        check("R2 oe", 32'(pad_oe), 32'({N{1'b1}}));
        check(session > 1 ? "R6 freq_sel" : (edges == WIN ? "R3 freq_sel" : "R4 freq_sel"),
              32'(freq_sel), 32'(cap[N-2:0]));
        check("R5 pin_mode", 32'(pin_mode), 32'(cap[N-1]));
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] p;
    p = 5'b10110;
    pad_in = p;
    repeat (3) @(negedge clk);
    // session 1: new pad value every cycle through and past the window
    session = 1;
    pwr_ok = 1'b1;
    for (int i = 0; i < WIN + 8; i++) begin
      @(negedge clk);
      p = p * 5 + 3;
      pad_in = p;
    end
    // session 2: drop within the window, then restart
    @(negedge clk);
    pwr_ok = 1'b0;
    pad_in = 5'b01001;
    repeat (2) @(negedge clk);
    session = 2;
    pwr_ok = 1'b1;
    repeat (5) @(negedge clk);
    pwr_ok = 1'b0;
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
    repeat (WIN + 4) @(negedge clk);
    pad_in = 5'b10110;
    repeat (3) @(negedge clk);
    // session 3: drop after capture, all-ones straps
    session = 3;
    pwr_ok = 1'b0;
    pad_in = 5'b11111;
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
    repeat (WIN + 2) @(negedge clk);
    pad_in = 5'b00000;
    repeat (4) @(negedge clk);
    @(posedge clk);
    #3;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule